// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Full Flag

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock. On the write side it produces an almost-full flag that changes only on write-clock edges. The flag's margin is programmable: it rises when the occupancy reaches the full depth minus a programmed offset.

A companion empty-side offset is stored next to the full-side offset. Both offsets are written through the normal write data port and read back through the normal read data port. While the load strobe of a port is high, that port steps through the offset pair instead of the FIFO. The empty offset always comes first and the full offset second.

A synchronous master reset (`mrst_i`) captures the depth-accounting mode from `fwft_sel_i`. It must be held for at least four edges of each clock.

- In standard mode the depth is `2**AW` words. A read request returns its word on the next read-clock edge.
- In fall-through mode the output register counts as one more word of storage, so the depth is `2**AW + 1`. The head word waits on the output already valid.

Back-pressure works as follows:

- **Write side:** a word is taken on a write-clock edge only when `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` falls when the storage array is full.
- **Read side:** a word is taken only when `rd_valid_o` and `rd_ready_i` are both high. In fall-through mode `rd_data_o` is stable while a valid word is held unaccepted.

Pointers cross the clock boundary in Gray code through two-flop synchronizers. Offsets are meant to be programmed while the FIFO is idle, and are treated as quasi-static across the boundary.

Top module: `paf_fifo`

## Requirements
- R1: After master reset the almost-full flag is 0, `wr_ready_o` is 1, `rd_valid_o` is 0, and readback returns the default empty offset (2) and then the default full offset (3).
- R2: Words leave the read port in exactly the order they were accepted at the write port, in both modes.
- R3: In standard mode (`fwft_sel_i` = 0 at reset), `rd_valid_o` is high whenever a word is stored. An accepted read places that word on `rd_data_o` after the same read-clock edge, and it is held there until the next accepted read.
- R4: In fall-through mode (`fwft_sel_i` = 1 at reset), the oldest word appears on `rd_data_o` with `rd_valid_o` high and no request. It stays unchanged while `rd_ready_i` is low.
- R5: `wr_ready_o` is low whenever the storage array holds `2**AW` words. With an idle reader, 16 words (standard) or 17 words (fall-through) are accepted before the write side stalls.
- R6: With full offset m and depth D, the almost-full flag is 1 right after the write-clock edge that accepts the word bringing the occupancy to D - m.
- R7: Once reads bring the occupancy to D - (m+1) or less, the flag returns to 0 within four write-clock edges of the last read edge. At occupancy D - m it stays 1.
- R8: While `wr_ld_i` is high, accepted beats write bits [AW:0] of `wr_data_i` into the empty offset, then the full offset, then the empty offset again. No such beat enters the FIFO.
- R9: While `rd_ld_i` is high, `rd_valid_o` is 1 and `rd_data_o` shows the selected offset, zero-extended. Each accepted beat steps from empty offset to full offset and back, and no FIFO word is consumed.
- R10: The mode is captured only during master reset. Changing `fwft_sel_i` afterwards has no effect.
- R11: In standard mode, a read request while `rd_valid_o` is low is ignored: `rd_data_o` keeps its value and no pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_i | input | 1 | Synchronous master reset, seen by both domains |
| fwft_sel_i | input | 1 | Mode select captured at reset: 1 = fall-through, 0 = standard |
| wr_valid_i | input | 1 | Write beat offered |
| wr_ready_o | output | 1 | Write beat can be taken |
| wr_ld_i | input | 1 | Route write beats to the offset pair |
| wr_data_i | input | DW | Write data or offset value |
| rd_valid_o | output | 1 | Read data (or offset) available |
| rd_ready_i | input | 1 | Read request / acceptance |
| rd_ld_i | input | 1 | Route the read port to the offset pair |
| rd_data_o | output | DW | Read data or offset value |
| almost_full_o | output | 1 | Programmable almost-full flag, write-clock domain |

## Verification
The hardest situation to reach is the fall-through fill to the one-word-deeper limit. The seventeenth word is only accepted once the head word has been moved into the output register across the clock boundary, so the array has room. The bench fills the FIFO with an idle reader and waits on `wr_ready_o` for each beat. It checks the flag at the exact threshold edge and checks that the write side has stalled. Flag release is checked by draining to one word above and then one word below the threshold, leaving synchronizer time between read and check.

// File: rtl/paf_fifo_pkg.sv
package paf_fifo_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } off_sel_e;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/paf_fifo_gray_sync.sv
module paf_fifo_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             gray_s;

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q <= '0;
    else       stage_q <= {stage_q[STAGES-2:0], gray_i};
  end

  assign gray_s = stage_q[STAGES-1];

  // gray -> binary: bit i is the parity of all bits at or above i
  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(gray_s >> i);
  end
endmodule

// File: rtl/paf_fifo_ram.sv
module paf_fifo_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/paf_fifo_wr.sv
module paf_fifo_wr
  import paf_fifo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int PW     = AW + 1,
  parameter int SYNC   = 2,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 3
) (
  input  logic          wclk_i,
  input  logic          mrst_i,
  input  logic          fwft_sel_i,
  input  logic          wr_valid_i,
  input  logic          wr_ld_i,
  input  logic [PW-1:0] wr_off_i,
  input  logic [PW-1:0] fetch_gray_i,
  input  logic [PW-1:0] pop_gray_i,
  output logic          wr_ready_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [PW-1:0] wcount_gray_o,
  output logic [PW-1:0] ae_off_o,
  output logic [PW-1:0] af_off_o,
  output logic [PW-1:0] ram_used_o,
  output logic          almost_full_o
);
  localparam int        DEPTH     = 1 << AW;
  localparam logic [PW:0] DMAX_STD  = (PW+1)'(DEPTH);
  localparam logic [PW:0] DMAX_FWFT = (PW+1)'(DEPTH + 1);

  logic [PW-1:0] wcount_q, wcount_nxt, wgray_q;
  logic [PW-1:0] fetch_bin, pop_bin, fill_nxt, af_nxt;
  logic [PW-1:0] ae_q, af_q;
  logic [PW:0]   depth_max, reach;
  fifo_mode_e    mode_q;
  off_sel_e      sel_q;
  logic          full, push, load, flag_q;

  paf_fifo_gray_sync #(.W(PW), .STAGES(SYNC)) u_sync_fetch (
    .clk_i(wclk_i), .rst_i(mrst_i), .gray_i(fetch_gray_i), .bin_o(fetch_bin));
  paf_fifo_gray_sync #(.W(PW), .STAGES(SYNC)) u_sync_pop (
    .clk_i(wclk_i), .rst_i(mrst_i), .gray_i(pop_gray_i), .bin_o(pop_bin));

  // array occupancy uses the fetch pointer; the flag uses the pop pointer
  assign ram_used_o = wcount_q - fetch_bin;
  assign full       = (ram_used_o == PW'(DEPTH));
  assign wr_ready_o = wr_ld_i | ~full;
  assign push       = wr_valid_i & ~wr_ld_i & ~full;
  assign load       = wr_valid_i & wr_ld_i;
  assign wcount_nxt = wcount_q + PW'(push);
  assign fill_nxt   = wcount_nxt - pop_bin;
  assign af_nxt     = (load && sel_q == SEL_FULL) ? wr_off_i : af_q;
  assign depth_max  = (mode_q == MODE_FWFT) ? DMAX_FWFT : DMAX_STD;
  assign reach      = {1'b0, fill_nxt} + {1'b0, af_nxt};

  always_ff @(posedge wclk_i) begin
    if (mrst_i) begin
      wcount_q <= '0;
      wgray_q  <= '0;
      sel_q    <= SEL_EMPTY;
      ae_q     <= PW'(AE_DEF);
      af_q     <= PW'(AF_DEF);
      flag_q   <= 1'b0;
      mode_q   <= fwft_sel_i ? MODE_FWFT : MODE_STD;
    end else begin
      wcount_q <= wcount_nxt;
      wgray_q  <= wcount_nxt ^ (wcount_nxt >> 1);
      flag_q   <= (reach >= depth_max);
      if (load) begin
        if (sel_q == SEL_EMPTY) ae_q <= wr_off_i;
        else                    af_q <= wr_off_i;
        sel_q <= (sel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
      end
    end
  end

  assign mem_we_o      = push;
  assign mem_waddr_o   = wcount_q[AW-1:0];
  assign wcount_gray_o = wgray_q;
  assign ae_off_o      = ae_q;
  assign af_off_o      = af_q;
  assign almost_full_o = flag_q;
endmodule

// File: rtl/paf_fifo_rd.sv
module paf_fifo_rd
  import paf_fifo_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int PW   = AW + 1,
  parameter int SYNC = 2
) (
  input  logic          rclk_i,
  input  logic          mrst_i,
  input  logic          fwft_sel_i,
  input  logic          rd_ready_i,
  input  logic          rd_ld_i,
  input  logic [PW-1:0] wcount_gray_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [PW-1:0] ae_off_i,
  input  logic [PW-1:0] af_off_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] mem_raddr_o,
  output logic [PW-1:0] fetch_gray_o,
  output logic [PW-1:0] pop_gray_o,
  output logic          fwft_o
);
  logic [PW-1:0] fetch_q, fetch_nxt, pop_q, pop_nxt, wbin;
  logic [PW-1:0] fgray_q, pgray_q;
  logic [DW-1:0] out_q;
  logic          out_full_q, ram_empty, fifo_valid, take, fetch;
  fifo_mode_e    mode_q;
  off_sel_e      rsel_q;

  paf_fifo_gray_sync #(.W(PW), .STAGES(SYNC)) u_sync_wr (
    .clk_i(rclk_i), .rst_i(mrst_i), .gray_i(wcount_gray_i), .bin_o(wbin));

  assign ram_empty  = (fetch_q == wbin);
  assign fifo_valid = (mode_q == MODE_FWFT) ? out_full_q : ~ram_empty;
  assign take       = rd_ready_i & ~rd_ld_i & fifo_valid;
  assign fetch      = (mode_q == MODE_FWFT) ? (~ram_empty & (~out_full_q | take)) : take;
  assign fetch_nxt  = fetch_q + PW'(fetch);
  assign pop_nxt    = pop_q + PW'(take);

  always_ff @(posedge rclk_i) begin
    if (mrst_i) begin
      fetch_q    <= '0;
      pop_q      <= '0;
      fgray_q    <= '0;
      pgray_q    <= '0;
      out_q      <= '0;
      out_full_q <= 1'b0;
      rsel_q     <= SEL_EMPTY;
      mode_q     <= fwft_sel_i ? MODE_FWFT : MODE_STD;
    end else begin
      fetch_q <= fetch_nxt;
      pop_q   <= pop_nxt;
      fgray_q <= fetch_nxt ^ (fetch_nxt >> 1);
      pgray_q <= pop_nxt ^ (pop_nxt >> 1);
      if (fetch) out_q <= mem_rdata_i;
      out_full_q <= (mode_q == MODE_FWFT) & (fetch | (out_full_q & ~take));
      if (rd_ld_i && rd_ready_i)
        rsel_q <= (rsel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end

  assign rd_valid_o   = rd_ld_i | fifo_valid;
  assign rd_data_o    = !rd_ld_i ? out_q :
                        (rsel_q == SEL_EMPTY) ? DW'(ae_off_i) : DW'(af_off_i);
  assign mem_raddr_o  = fetch_q[AW-1:0];
  assign fetch_gray_o = fgray_q;
  assign pop_gray_o   = pgray_q;
  assign fwft_o       = (mode_q == MODE_FWFT);
endmodule

// File: rtl/paf_fifo.sv
module paf_fifo #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int SYNC   = 2,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 3
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          mrst_i,
  input  logic          fwft_sel_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic          wr_ld_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  input  logic          rd_ld_i,
  output logic [DW-1:0] rd_data_o,
  output logic          almost_full_o
);
  localparam int PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] wcount_gray, fetch_gray, pop_gray, ae_off, af_off, w_ram_used;
  logic          r_fwft;

  paf_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(wr_data_i),
    .raddr_i(mem_raddr), .rdata_o(mem_rdata));

  paf_fifo_wr #(.AW(AW), .PW(PW), .SYNC(SYNC), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .wclk_i(wclk_i), .mrst_i(mrst_i), .fwft_sel_i(fwft_sel_i),
    .wr_valid_i(wr_valid_i), .wr_ld_i(wr_ld_i), .wr_off_i(wr_data_i[PW-1:0]),
    .fetch_gray_i(fetch_gray), .pop_gray_i(pop_gray), .wr_ready_o(wr_ready_o),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .wcount_gray_o(wcount_gray),
    .ae_off_o(ae_off), .af_off_o(af_off), .ram_used_o(w_ram_used),
    .almost_full_o(almost_full_o));

  paf_fifo_rd #(.DW(DW), .AW(AW), .PW(PW), .SYNC(SYNC)) u_rd (
    .rclk_i(rclk_i), .mrst_i(mrst_i), .fwft_sel_i(fwft_sel_i),
    .rd_ready_i(rd_ready_i), .rd_ld_i(rd_ld_i), .wcount_gray_i(wcount_gray),
    .mem_rdata_i(mem_rdata), .ae_off_i(ae_off), .af_off_i(af_off),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .mem_raddr_o(mem_raddr),
    .fetch_gray_o(fetch_gray), .pop_gray_o(pop_gray), .fwft_o(r_fwft));
endmodule

// File: rtl/paf_fifo_chk.sv
module paf_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          mrst_i,
  input logic          wr_valid_i,
  input logic          wr_ready_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic          rd_ld_i,
  input logic [DW-1:0] rd_data_o,
  input logic          almost_full_o,
  input logic [AW:0]   ram_used_i,
  input logic          rd_fwft_i
);
  localparam int DEPTH = 1 << AW;

  // R1
  reset_clears_chk: assert property (@(posedge wclk_i)
    mrst_i |=> (!almost_full_o && wr_ready_o));

  // R5
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (mrst_i)
    ram_used_i <= (AW+1)'(DEPTH));

  // R4
  head_hold_chk: assert property (@(posedge rclk_i) disable iff (mrst_i)
    (rd_fwft_i && rd_valid_o && !rd_ready_i && !rd_ld_i)
      |=> (rd_ld_i || (rd_valid_o && $stable(rd_data_o))));

  // R6
  flag_rise_chk: assert property (@(posedge wclk_i) disable iff (mrst_i)
    $rose(almost_full_o) |-> $past(wr_valid_i && wr_ready_o));

  // R11
  empty_read_chk: assert property (@(posedge rclk_i) disable iff (mrst_i)
    (!rd_fwft_i && !rd_valid_o) |=> (rd_ld_i || $stable(rd_data_o)));
endmodule

bind paf_fifo paf_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .mrst_i(mrst_i),
  .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_ld_i(rd_ld_i),
  .rd_data_o(rd_data_o), .almost_full_o(almost_full_o),
  .ram_used_i(w_ram_used), .rd_fwft_i(r_fwft));

// File: tb/test_paf_fifo.sv
`timescale 1ns/100ps
module test_paf_fifo;
  localparam int DW = 16;
  localparam int AW = 4;

  logic wclk = 0, rclk = 0, mrst = 1, fwft_sel = 0;
  logic wr_valid = 0, wr_ld = 0, rd_ready = 0, rd_ld = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, almost_full;
  logic [DW-1:0] rd_data;
  logic fwft_now = 0;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q [$];

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  paf_fifo #(.DW(DW), .AW(AW)) i_paf_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .mrst_i(mrst), .fwft_sel_i(fwft_sel),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_ld_i(wr_ld), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_ld_i(rd_ld), .rd_data_o(rd_data),
    .almost_full_o(almost_full));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_reset(input logic fw);
    mrst = 1; fwft_sel = fw; fwft_now = fw;
    wr_valid = 0; wr_ld = 0; rd_ready = 0; rd_ld = 0;
    repeat (5) @(posedge rclk);
    @(negedge wclk); mrst = 0;
    exp_q.delete();
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(negedge wclk);
  endtask

  // driver: offers one beat, pushes expected word once accepted
  task automatic wr_beat(input logic ld, input logic [DW-1:0] d);
    @(negedge wclk);
    wr_valid = 1; wr_ld = ld; wr_data = d;
    #0.5;
    while (!wr_ready) begin @(negedge wclk); #0.5; end
    @(posedge wclk); #0.5;
    wr_valid = 0; wr_ld = 0;
    if (!ld) exp_q.push_back(d);
  endtask

  // monitor side: takes one word and compares with the scoreboard head
  task automatic rd_beat(input string req);
    logic [DW-1:0] e;
    @(negedge rclk);
    while (!rd_valid) @(negedge rclk);
    e = exp_q.pop_front();
    if (fwft_now) chk(req, rd_data, e);
    rd_ready = 1;
    @(posedge rclk); #0.5;
    rd_ready = 0;
    if (!fwft_now) chk(req, rd_data, e);
  endtask

  task automatic rb(input logic [DW-1:0] e);
    @(negedge rclk);
    rd_ld = 1; #0.5;
    chk("R9 readback valid", rd_valid, 1);
    chk("R9 readback value", rd_data, e);
    rd_ready = 1;
    @(posedge rclk); #0.5;
    rd_ready = 0; rd_ld = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] last;
    // ---------------- standard mode ----------------
    do_reset(0);
    chk("R1 flag after reset", almost_full, 0);
    chk("R1 wr_ready after reset", wr_ready, 1);
    chk("R1 rd_valid after reset", rd_valid, 0);
    rb(2); rb(3); rb(2);                       // R1 defaults, R9 wrap
    rb(3);
    wr_beat(1, 16'h0005); wr_beat(1, 16'h0004);  // R8: empty=5, full=4
    wait_w(10);
    chk("R8 load adds no word", rd_valid, 0);
    rb(5); rb(4);                               // R8 values read back
    for (int i = 0; i < 11; i++) wr_beat(0, 16'h0100 + 16'(i));
    chk("R6 below threshold", almost_full, 0);
    wr_beat(0, 16'h010B);
    chk("R6 at D-m (12)", almost_full, 1);
    for (int i = 12; i < 16; i++) wr_beat(0, 16'h0100 + 16'(i));
    wait_w(8);
    chk("R5 stall at 16 words", wr_ready, 0);
    for (int i = 0; i < 4; i++) rd_beat("R3 R2 standard read");
    wait_w(8);
    chk("R7 still set at D-m", almost_full, 1);
    rd_beat("R3 R2 standard read");
    wait_w(8);
    chk("R7 clear at D-(m+1)", almost_full, 0);
    while (exp_q.size() > 0) rd_beat("R2 standard drain");
    wait_w(8);
    chk("R3 empty -> not valid", rd_valid, 0);
    last = rd_data;
    @(negedge rclk); rd_ready = 1;
    @(posedge rclk); #0.5; rd_ready = 0;
    chk("R11 empty read ignored", rd_data, last);
    // R10: mode pin changes without reset
    fwft_sel = 1;
    wr_beat(0, 16'h0ABC);
    repeat (10) @(negedge rclk);
    chk("R10 still standard, no fall-through", rd_data, last);
    chk("R10 word stored", rd_valid, 1);
    rd_beat("R10 R2 read after pin change");

    // ---------------- fall-through mode ----------------
    do_reset(1);
    chk("R1 fwft flag after reset", almost_full, 0);
    rb(2); rb(3);
    for (int i = 0; i < 13; i++) wr_beat(0, 16'h2000 + 16'(i));
    chk("R6 fwft below threshold", almost_full, 0);
    wr_beat(0, 16'h200D);
    chk("R6 fwft at D-m (14)", almost_full, 1);
    repeat (10) @(negedge rclk);
    chk("R4 head valid", rd_valid, 1);
    chk("R4 head data", rd_data, exp_q[0]);
    repeat (3) @(negedge rclk);
    chk("R4 head held", rd_data, exp_q[0]);
    for (int i = 14; i < 17; i++) wr_beat(0, 16'h2000 + 16'(i));
    wait_w(8);
    chk("R5 fwft stall at 17 words", wr_ready, 0);
    for (int i = 0; i < 3; i++) rd_beat("R4 R2 fwft read");
    wait_w(8);
    chk("R7 fwft set at 14", almost_full, 1);
    rd_beat("R4 R2 fwft read");
    wait_w(8);
    chk("R7 fwft clear at 13", almost_full, 0);
    while (exp_q.size() > 0) rd_beat("R2 fwft drain");
    wr_beat(1, 16'h0007); wr_beat(1, 16'h0000);
    wait_w(10);
    chk("R8 fwft load adds no word", rd_valid, 0);
    rb(7); rb(0);

    // streaming with irregular gaps on both sides
    fork
      for (int i = 0; i < 40; i++) begin
        wr_beat(0, 16'h4000 + 16'(i));
        repeat ($urandom_range(0, 3)) @(negedge wclk);
      end
      for (int i = 0; i < 40; i++) begin
        repeat ($urandom_range(0, 4)) @(negedge rclk);
        rd_beat("R2 R4 streaming order");
      end
    join
    chk("R2 scoreboard empty", exp_q.size(), 0);
    summary();
  end
endmodule